// File: doc/BRIEF.md
# UART Modem Handshake Control and Status

This block holds the modem handshake state of a serial port. Four active-low handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) are synchronized to the block clock. The block presents their present levels and their change flags in one 8-bit status word. A status read strobe clears the change flags. When the modem interrupt enable is high, any pending change flag raises an interrupt request.

A 5-bit control register drives four active-low output pins: data-terminal-ready, request-to-send and two general-purpose outputs. Its top bit selects loop mode, which holds all four pins inactive. Bus address decode, interrupt prioritisation and the serial data paths sit outside this block.

Top module: `modem_ctl_stat`

## Requirements
- R1: While `rst` is high, the control register clears, all four change flags clear and `irq` is low. One clock after reset, `ctl_q` is 0 and all four output pins are high.
- R2: Status bits 4, 5, 6 and 7 show the inverted level of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`, in that order. A pin change reaches its status bit after two rising clock edges.
- R3: Status bit 0 (`cts_n`), bit 1 (`dsr_n`) and bit 3 (`dcd_n`) set when their pin changes in either direction. The flag is visible after three rising edges.
- R4: Status bit 2 sets only when `ri_n` goes from low to high, which is the ring going inactive. A high-to-low change of `ri_n` leaves bit 2 unchanged.
- R5: A cycle with `sts_rd` high clears all change flags at the next edge.
- R6: If a change is detected in the same cycle as a status read, its flag stays set after the read. The other flags clear.
- R7: `irq` is high exactly when `irq_en` is high and at least one of status bits 0 to 3 is set.
- R8: A `ctl_wr` cycle loads `ctl_d` into the control register. Outside loop mode, control bits 0, 1, 2 and 3 drive `dtr_n`, `rts_n`, `out1_n` and `out2_n` low when set, and high when clear.
- R9: While control bit 4 (loop mode) is set, all four output pins are high whatever bits 0 to 3 hold.
- R10: A change flag, once set, holds until a status read clears it, whatever the pins do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Master reset, active high, synchronous |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| sts_rd | input | 1 | Status read strobe; clears change flags |
| sts_q | output | 8 | Status word: levels in bits 7..4, change flags in bits 3..0 |
| irq_en | input | 1 | Modem interrupt enable |
| irq | output | 1 | Modem interrupt request |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_d | input | 5 | Control write data |
| ctl_q | output | 5 | Control register contents |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |

## Verification
The bench walks all sixteen pin combinations in sequence and predicts each flag from the previous and next combination. Flagging both ring edges, or neither, would break the ring-flag prediction. A read that clears everything at once, including a change caught on the read cycle, would lose that event; the bench stages that collision on purpose. It also checks that flags survive the pins returning to their old level, since a flag that tracked the level instead of latching would be lost. All 32 control values are written, so a loop mode that misses one output pin, or a swapped pin mapping, is caught.

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       sts_rd,
  output logic [7:0] sts_q,
  input  logic       irq_en,
  output logic       irq,
  input  logic       ctl_wr,
  input  logic [4:0] ctl_d,
  output logic [4:0] ctl_q,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       out1_n,
  output logic       out2_n
);

  logic [3:0] pins, s, prev, chg, delta;
  logic [3:0] sync_q [SYNC_STAGES];
  logic [4:0] ctl;
  logic       loop_on;

  assign pins = {dcd_n, ri_n, dsr_n, cts_n};
  assign s    = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
      prev <= '1;
    end else begin
      sync_q[0] <= pins;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev <= s;
    end
  end

  // ring flag only on the inactive-going (low to high) pin edge
  assign chg = {s[3] ^ prev[3], s[2] & ~prev[2], s[1] ^ prev[1], s[0] ^ prev[0]};

  always_ff @(posedge clk) begin
    if (rst) delta <= '0;
    else     delta <= (delta & ~{4{sts_rd}}) | chg;
  end

  always_ff @(posedge clk) begin
    if (rst)         ctl <= '0;
    else if (ctl_wr) ctl <= ctl_d;
  end

  assign loop_on = ctl[4];
  assign sts_q   = {~s, delta};
  assign irq     = irq_en & (|delta);
  assign ctl_q   = ctl;
  assign dtr_n   = ~(ctl[0] & ~loop_on);
  assign rts_n   = ~(ctl[1] & ~loop_on);
  assign out1_n  = ~(ctl[2] & ~loop_on);
  assign out2_n  = ~(ctl[3] & ~loop_on);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ctl_q == 5'd0 && sts_q[3:0] == 4'd0 && !irq));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    !sts_rd |=> ((sts_q[3:0] & $past(sts_q[3:0])) == $past(sts_q[3:0])));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (sts_rd && chg == 4'd0) |=> (sts_q[3:0] == 4'd0));

  a_r6_read_keeps_new: assert property (@(posedge clk) disable iff (rst)
    (sts_rd && chg != 4'd0) |=> ((sts_q[3:0] & $past(chg)) == $past(chg)));

  a_r4_ring_on_no_flag: assert property (@(posedge clk) disable iff (rst)
    (!sts_q[2] && prev[2] && !s[2]) |=> !sts_q[2]);

  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_en && sts_q[3:0] != 4'd0));

  a_r9_loop_quiet: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_d[4]) |=> ({dtr_n, rts_n, out1_n, out2_n} == 4'hF));

endmodule

// File: tb/sim_modem_ctl_stat.sv
module sim_modem_ctl_stat;
  logic clk = 0, rst = 1;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic sts_rd = 0, irq_en = 0, ctl_wr = 0;
  logic [4:0] ctl_d = '0;
  logic [7:0] sts_q;
  logic [4:0] ctl_q;
  logic irq, dtr_n, rts_n, out1_n, out2_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modem_ctl_stat u0 (.clk(clk), .rst(rst), .cts_n(cts_n), .dsr_n(dsr_n),
    .ri_n(ri_n), .dcd_n(dcd_n), .sts_rd(sts_rd), .sts_q(sts_q),
    .irq_en(irq_en), .irq(irq), .ctl_wr(ctl_wr), .ctl_d(ctl_d),
    .ctl_q(ctl_q), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n),
    .out2_n(out2_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [3:0] p);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  task automatic do_read();
    sts_rd = 1; edges(1); sts_rd = 0;
  endtask

  initial begin
    logic [3:0] prev_p, exp_d;
    logic [3:0] exp_pins;
    edges(3);
    chk(ctl_q == 0 && sts_q == 8'h00 && !irq, "R1 reset state", sts_q, 0);
    chk({dtr_n, rts_n, out1_n, out2_n} == 4'hF, "R1 pins idle", {dtr_n, rts_n, out1_n, out2_n}, 15);
    rst = 0;
    edges(2);

    // R2 R3 R4 R7: walk all pin combinations
    prev_p = 4'hF;
    irq_en = 1;
    for (int k = 1; k <= 16; k++) begin
      logic [3:0] p;
      p = 4'(k) ^ 4'hF;
      set_pins(p);
      edges(1);
      chk(sts_q[7:4] == ~prev_p, "R2 level latency", sts_q[7:4], ~prev_p);
      edges(1);
      chk(sts_q[7:4] == ~p, "R2 levels", sts_q[7:4], ~p);
      edges(1);
      exp_d = {p[3] ^ prev_p[3], p[2] & ~prev_p[2], p[1] ^ prev_p[1], p[0] ^ prev_p[0]};
      chk(sts_q[3:0] == exp_d, "R3 R4 change flags", sts_q[3:0], exp_d);
      chk(irq == (exp_d != 0), "R7 irq enabled", irq, exp_d != 0);
      do_read();
      chk(sts_q[3:0] == 0, "R5 read clears", sts_q[3:0], 0);
      prev_p = p;
    end

    // R7: disabled interrupt stays low with pending flag
    irq_en = 0;
    set_pins(4'hE); edges(3);
    chk(sts_q[0] && !irq, "R7 irq disabled", {sts_q[0], irq}, 2);
    irq_en = 1; #1;
    chk(irq, "R7 irq re-enabled", irq, 1);

    // R10: flag holds after pin returns
    set_pins(4'hF); edges(3);
    chk(sts_q[0], "R10 sticky after return", sts_q[0], 1);
    do_read();

    // R6: dsr change caught on the read cycle, cts flag old
    set_pins(4'hE); edges(3);
    set_pins(4'hC); edges(2);
    sts_rd = 1; edges(1); sts_rd = 0;
    chk(sts_q[3:0] == 4'b0010, "R6 same-cycle change kept", sts_q[3:0], 2);
    do_read();
    chk(sts_q[3:0] == 0, "R5 second read", sts_q[3:0], 0);

    // R4: ring active alone gives no flag
    set_pins(4'hF); edges(3); do_read();
    set_pins(4'hB); edges(3);
    chk(sts_q[2] == 0, "R4 ring activate ignored", sts_q[2], 0);
    set_pins(4'hF); edges(3);
    chk(sts_q[2] == 1, "R4 ring release flagged", sts_q[2], 1);
    do_read();

    // R8 R9: all control values
    for (int w = 0; w < 32; w++) begin
      logic [4:0] wv;
      wv = 5'(w);
      ctl_d = wv; ctl_wr = 1; edges(1); ctl_wr = 0;
      exp_pins = wv[4] ? 4'hF : ~{wv[0], wv[1], wv[2], wv[3]};
      chk(ctl_q == wv, "R8 control readback", ctl_q, wv);
      chk({dtr_n, rts_n, out1_n, out2_n} == exp_pins,
          wv[4] ? "R9 loop pins" : "R8 control pins",
          {dtr_n, rts_n, out1_n, out2_n}, exp_pins);
    end

    // R1: reset after activity
    ctl_d = 5'h0F; ctl_wr = 1; edges(1); ctl_wr = 0;
    set_pins(4'h0); edges(3);
    rst = 1; edges(1); rst = 0;
    set_pins(4'hF);
    chk(ctl_q == 0 && sts_q[3:0] == 0 && !irq, "R1 reset clears", {ctl_q, sts_q[3:0]}, 0);
    chk({dtr_n, rts_n, out1_n, out2_n} == 4'hF, "R1 pins after reset", {dtr_n, rts_n, out1_n, out2_n}, 15);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule